// File: doc/BRIEF.md
# Atomic Read-Modify-Write Arithmetic Unit

This block holds the arithmetic of an atomic memory operation. Given an operation code, an access width, the source operand and the data just loaded from memory, it produces two things: the data to store back, cut to the access width and paired with a byte-enable mask, and the old value to return to the destination register, widened to the full register width. Memory sequencing, address handling, ordering and exceptions belong to the surrounding load/store unit. The comparison half of compare-and-swap does too. Each operation works on a single register.

The register width is set by the `XLEN` parameter (32 or 64). Both operands are narrowed to the access width. They are then widened again with zero fill for the two unsigned min/max operations and with sign fill for every other operation. The old value returned to the register is always sign-filled. Illegal combinations raise a flag and produce no store. All outputs are registered, so a result appears one clock after its inputs.

Top module: `amo_rmw_unit`

## Requirements
- R1: Operation codes: 0 swap, 1 add, 2 xor, 3 and, 4 or, 5 signed min, 6 signed max, 7 unsigned min, 8 unsigned max, 9 compare-and-swap. Swap stores the operand. Add stores operand plus loaded value, wrapping modulo 2^XLEN with no carry output. Xor, and and or store the bitwise result.
- R2: Signed min (5) and signed max (6) store the smaller or larger of the two widened values, compared in two's complement.
- R3: Unsigned min (7) and unsigned max (8) store the smaller or larger of the two widened values, compared as unsigned numbers.
- R4: Width codes: 0 byte, 1 half (16 bits), 2 word (32 bits), 3 full XLEN. For widths 0 to 2, both the operand and the loaded value keep only their low 8, 16 or 32 bits. They are widened with zero fill for codes 7 and 8 and with sign fill for all other codes. At full width, both pass through unchanged.
- R5: Compare-and-swap (9) stores the widened operand, the same data as swap.
- R6: The returned old value is the loaded data sign-filled from the access width, for every operation including codes 7 and 8. At full width it is returned unchanged.
- R7: Store data holds the result only in the low 1, 2, 4 or 8 bytes given by the width, with zeros above. The byte mask has bit i set exactly for those bytes: 0x01, 0x03, 0x0F, or all XLEN/8 bits.
- R8: With XLEN=32, width code 3 is illegal. The illegal flag goes high and store data, byte mask and returned value are all zero.
- R9: Operation codes 10 to 15 are illegal, with the same flag and all-zero outputs as R8.
- R10: Outputs change exactly one rising clock edge after their inputs. While reset is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code (R1) |
| width_i | input | 2 | Access width code (R4) |
| rs2_i | input | XLEN | Source operand from the register file |
| ld_i | input | XLEN | Data loaded from memory |
| st_data_o | output | XLEN | Data to store, zero above the access width |
| st_mask_o | output | XLEN/8 | Byte enables for the store |
| ret_o | output | XLEN | Old value for the destination register |
| illegal_o | output | 1 | Illegal operation code or width |

## Verification
The properties assume that every input is a known value at each rising edge once reset is released. The properties that use `$past` also assume that the inputs captured on the first edge after reset are meaningful. The bench satisfies both conditions: it drives all inputs to zero before releasing reset, and it changes them only on falling edges. The bench also uses only codes 0 to 15 and widths 0 to 3. Undefined operation codes are therefore exercised deliberately, as defined inputs, and never appear as unknown values.

// File: rtl/amo_rmw_pkg.sv
package amo_rmw_pkg;

    typedef enum logic [3:0] {
        AMO_SWAP = 4'd0,
        AMO_ADD  = 4'd1,
        AMO_XOR  = 4'd2,
        AMO_AND  = 4'd3,
        AMO_OR   = 4'd4,
        AMO_MIN  = 4'd5,
        AMO_MAX  = 4'd6,
        AMO_MINU = 4'd7,
        AMO_MAXU = 4'd8,
        AMO_CAS  = 4'd9
    } amo_op_e;

    typedef enum logic [1:0] {
        AW_BYTE = 2'd0,
        AW_HALF = 2'd1,
        AW_WORD = 2'd2,
        AW_FULL = 2'd3
    } amo_width_e;

    localparam logic [3:0] AMO_LAST_CODE = 4'd9;

    function automatic logic op_is_unsigned(input logic [3:0] op);
        return (op == AMO_MINU) || (op == AMO_MAXU);
    endfunction

endpackage

// File: rtl/amo_narrow_ext.sv
// Keeps the low bits selected by the width code and fills the rest
// with zeros or with copies of the top kept bit.
module amo_narrow_ext #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] val_i,
    input  logic [1:0]      width_i,
    input  logic            sign_i,
    output logic [XLEN-1:0] val_o
);
    import amo_rmw_pkg::*;

    logic [XLEN-1:0] keep_mask;
    logic            top_bit;

    always_comb begin
        case (amo_width_e'(width_i))
            AW_BYTE: begin keep_mask = XLEN'(8'hFF);         top_bit = val_i[7];  end
            AW_HALF: begin keep_mask = XLEN'(16'hFFFF);      top_bit = val_i[15]; end
            AW_WORD: begin keep_mask = XLEN'(32'hFFFF_FFFF); top_bit = val_i[31]; end
            default: begin keep_mask = '1;                   top_bit = 1'b0;      end
        endcase
        val_o = (val_i & keep_mask) | ((sign_i && top_bit) ? ~keep_mask : '0);
    end
endmodule

// File: rtl/amo_op_core.sv
// Combines the two widened operands according to the operation code.
module amo_op_core #(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op_i,
    input  logic [XLEN-1:0] opnd_i,
    input  logic [XLEN-1:0] mem_i,
    output logic [XLEN-1:0] result_o
);
    import amo_rmw_pkg::*;

    logic lt_signed;
    logic lt_unsigned;

    always_comb begin
        lt_signed   = $signed(opnd_i) < $signed(mem_i);
        lt_unsigned = opnd_i < mem_i;
        case (amo_op_e'(op_i))
            AMO_ADD:  result_o = opnd_i + mem_i;
            AMO_XOR:  result_o = opnd_i ^ mem_i;
            AMO_AND:  result_o = opnd_i & mem_i;
            AMO_OR:   result_o = opnd_i | mem_i;
            AMO_MIN:  result_o = lt_signed   ? opnd_i : mem_i;
            AMO_MAX:  result_o = lt_signed   ? mem_i  : opnd_i;
            AMO_MINU: result_o = lt_unsigned ? opnd_i : mem_i;
            AMO_MAXU: result_o = lt_unsigned ? mem_i  : opnd_i;
            default:  result_o = opnd_i;   // swap, compare-and-swap
        endcase
    end
endmodule

// File: rtl/amo_store_mask.sv
// Cuts the result to the access width and forms the byte enables.
module amo_store_mask #(
    parameter int XLEN = 64
) (
    input  logic [1:0]        width_i,
    input  logic              kill_i,
    input  logic [XLEN-1:0]   result_i,
    output logic [XLEN-1:0]   st_data_o,
    output logic [XLEN/8-1:0] st_mask_o
);
    localparam int NBYTES = XLEN / 8;

    logic [4:0] live_bytes;
    assign live_bytes = 5'd1 << width_i;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign st_mask_o[b]          = !kill_i && (5'(b) < live_bytes);
        assign st_data_o[8*b +: 8]   = st_mask_o[b] ? result_i[8*b +: 8] : 8'h00;
    end
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit #(
    parameter int XLEN = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        op_i,
    input  logic [1:0]        width_i,
    input  logic [XLEN-1:0]   rs2_i,
    input  logic [XLEN-1:0]   ld_i,
    output logic [XLEN-1:0]   st_data_o,
    output logic [XLEN/8-1:0] st_mask_o,
    output logic [XLEN-1:0]   ret_o,
    output logic              illegal_o
);
    import amo_rmw_pkg::*;

    localparam int  NBYTES     = XLEN / 8;
    localparam bit  FULL_LEGAL = (XLEN == 64);

    typedef struct packed {
        logic [XLEN-1:0]   st_data;
        logic [NBYTES-1:0] st_mask;
        logic [XLEN-1:0]   ret;
        logic              illegal;
    } amo_out_t;

    amo_out_t out_d, out_q;

    logic            use_sign;
    logic            bad_combo;
    logic [XLEN-1:0] opnd_ext;
    logic [XLEN-1:0] mem_ext;
    logic [XLEN-1:0] ret_ext;
    logic [XLEN-1:0] result;
    logic [XLEN-1:0] st_data;
    logic [NBYTES-1:0] st_mask;

    assign use_sign  = !op_is_unsigned(op_i);
    assign bad_combo = (op_i > AMO_LAST_CODE) ||
                       (!FULL_LEGAL && (width_i == AW_FULL));

    amo_narrow_ext #(.XLEN(XLEN)) u_opnd_ext (
        .val_i(rs2_i), .width_i(width_i), .sign_i(use_sign), .val_o(opnd_ext)
    );

    amo_narrow_ext #(.XLEN(XLEN)) u_mem_ext (
        .val_i(ld_i), .width_i(width_i), .sign_i(use_sign), .val_o(mem_ext)
    );

    amo_narrow_ext #(.XLEN(XLEN)) u_ret_ext (
        .val_i(ld_i), .width_i(width_i), .sign_i(1'b1), .val_o(ret_ext)
    );

    amo_op_core #(.XLEN(XLEN)) u_core (
        .op_i(op_i), .opnd_i(opnd_ext), .mem_i(mem_ext), .result_o(result)
    );

    amo_store_mask #(.XLEN(XLEN)) u_store (
        .width_i(width_i), .kill_i(bad_combo), .result_i(result),
        .st_data_o(st_data), .st_mask_o(st_mask)
    );

    always_comb begin
        out_d.st_data = st_data;
        out_d.st_mask = st_mask;
        out_d.ret     = bad_combo ? '0 : ret_ext;
        out_d.illegal = bad_combo;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign st_data_o = out_q.st_data;
    assign st_mask_o = out_q.st_mask;
    assign ret_o     = out_q.ret;
    assign illegal_o = out_q.illegal;
endmodule

// File: rtl/amo_rmw_checker.sv
module amo_rmw_checker #(
    parameter int XLEN = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [3:0]        op_i,
    input logic [1:0]        width_i,
    input logic [XLEN-1:0]   rs2_i,
    input logic [XLEN-1:0]   ld_i,
    input logic [XLEN-1:0]   st_data_o,
    input logic [XLEN/8-1:0] st_mask_o,
    input logic [XLEN-1:0]   ret_o,
    input logic              illegal_o
);
    localparam int NBYTES = XLEN / 8;

    logic [XLEN-1:0] mask_bits;
    for (genvar b = 0; b < NBYTES; b++) begin : g_bits
        assign mask_bits[8*b +: 8] = {8{st_mask_o[b]}};
    end

    // R8 / R9: an illegal result carries nothing
    p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> (st_mask_o == '0 && st_data_o == '0 && ret_o == '0));

    // R9: undefined codes are flagged one edge later
    p_bad_op_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i > 4'd9) |=> illegal_o);

    // R7: byte enables form a contiguous run from byte 0
    p_mask_contig_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({1'b0, st_mask_o} + 1'b1));

    // R7: no store data outside enabled bytes
    p_data_in_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_data_o & ~mask_bits) == '0);

    // R6: byte access returns sign-filled loaded byte
    p_ret_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (width_i == 2'd0 && op_i <= 4'd9) |=>
        ret_o == {{(XLEN-8){$past(ld_i[7])}}, $past(ld_i[7:0])});

    // R1: swap stores the operand byte
    p_swap_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == 4'd0 && width_i == 2'd0) |=> st_data_o[7:0] == $past(rs2_i[7:0]));
endmodule

bind amo_rmw_unit amo_rmw_checker #(.XLEN(XLEN)) u_amo_rmw_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .width_i(width_i),
    .rs2_i(rs2_i), .ld_i(ld_i), .st_data_o(st_data_o), .st_mask_o(st_mask_o),
    .ret_o(ret_o), .illegal_o(illegal_o)
);

// File: tb/amo_rmw_unit_bench.sv
module amo_rmw_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  wd = '0;
    logic [63:0] rs2 = '0;
    logic [63:0] ld = '0;

    logic [63:0] st64, ret64;
    logic [7:0]  mask64;
    logic        ill64;
    logic [31:0] st32, ret32;
    logic [3:0]  mask32;
    logic        ill32;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    amo_rmw_unit #(.XLEN(64)) u_amo_rmw_unit (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .width_i(wd),
        .rs2_i(rs2), .ld_i(ld), .st_data_o(st64), .st_mask_o(mask64),
        .ret_o(ret64), .illegal_o(ill64)
    );

    amo_rmw_unit #(.XLEN(32)) u_amo_rmw_unit_32 (
        .clk_i(clk), .rst_ni(rst_n), .op_i(op), .width_i(wd),
        .rs2_i(rs2[31:0]), .ld_i(ld[31:0]), .st_data_o(st32), .st_mask_o(mask32),
        .ret_o(ret32), .illegal_o(ill32)
    );

    // ---- reference model written from the requirements ----
    function automatic logic [63:0] widen(input logic [63:0] v, input logic [1:0] w,
                                          input bit sgn, input int xl);
        int n = (w == 2'd3) ? xl : (8 << w);
        logic [63:0] keep = (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
        logic [63:0] xm   = (xl == 64) ? '1 : 64'hFFFF_FFFF;
        logic [63:0] r    = v & keep;
        if (sgn && v[n-1]) r = r | ~keep;
        return r & xm;
    endfunction

    task automatic model(input int xl, input logic [3:0] o, input logic [1:0] w,
                         input logic [63:0] a_in, input logic [63:0] m_in,
                         output logic [63:0] e_st, output logic [7:0] e_mask,
                         output logic [63:0] e_ret, output logic e_ill);
        logic [63:0] xm = (xl == 64) ? '1 : 64'hFFFF_FFFF;
        bit uns = (o == 4'd7 || o == 4'd8);
        logic [63:0] a = widen(a_in, w, !uns, xl);
        logic [63:0] m = widen(m_in, w, !uns, xl);
        logic [63:0] r;
        bit slt, ult;
        int nb = (w == 2'd3) ? xl / 8 : (1 << w);
        logic [63:0] keep = (nb >= 8) ? '1 : ((64'd1 << (8*nb)) - 64'd1);
        slt = (xl == 32) ? ($signed(a[31:0]) < $signed(m[31:0])) : ($signed(a) < $signed(m));
        ult = a < m;
        case (o)
            4'd1: r = (a + m) & xm;
            4'd2: r = a ^ m;
            4'd3: r = a & m;
            4'd4: r = a | m;
            4'd5: r = slt ? a : m;
            4'd6: r = slt ? m : a;
            4'd7: r = ult ? a : m;
            4'd8: r = ult ? m : a;
            default: r = a;
        endcase
        e_ill = (o > 4'd9) || (xl == 32 && w == 2'd3);
        if (e_ill) begin
            e_st = '0; e_mask = '0; e_ret = '0;
        end else begin
            e_st   = r & keep;
            e_mask = 8'((9'd1 << nb) - 9'd1);
            e_ret  = widen(m_in, w, 1'b1, xl);
        end
    endtask

    task automatic expect_eq(input string req, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input string req, input int xl, input logic [3:0] o,
                            input logic [1:0] w, input logic [63:0] a, input logic [63:0] m);
        logic [63:0] e_st, e_ret;
        logic [7:0]  e_mask;
        logic        e_ill;
        @(negedge clk);
        op = o; wd = w; rs2 = a; ld = m;
        @(posedge clk);
        @(negedge clk);
        model(xl, o, w, a, m, e_st, e_mask, e_ret, e_ill);
        if (xl == 64) begin
            expect_eq(req, "store", st64, e_st);
            expect_eq(req, "mask", {56'd0, mask64}, {56'd0, e_mask});
            expect_eq(req, "ret", ret64, e_ret);
            expect_eq(req, "illegal", {63'd0, ill64}, {63'd0, e_ill});
        end else begin
            expect_eq(req, "store", {32'd0, st32}, e_st);
            expect_eq(req, "mask", {60'd0, mask32}, {56'd0, e_mask});
            expect_eq(req, "ret", {32'd0, ret32}, e_ret);
            expect_eq(req, "illegal", {63'd0, ill32}, {63'd0, e_ill});
        end
    endtask

    // ---- scenarios ----
    task automatic t_reset_r10();
        #1;
        expect_eq("R10", "reset store", st64, '0);
        expect_eq("R10", "reset ret", ret64, '0);
        expect_eq("R10", "reset mask", {56'd0, mask64}, '0);
        expect_eq("R10", "reset illegal", {63'd0, ill64}, '0);
    endtask

    task automatic t_basic_r1();
        run_case("R1", 64, 4'd0, 2'd3, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000);
        run_case("R1", 64, 4'd1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
        run_case("R1", 64, 4'd1, 2'd2, 64'h0000_0000_7FFF_FFFF, 64'd1);
        run_case("R1", 64, 4'd2, 2'd3, 64'hF0F0_F0F0_0F0F_0F0F, 64'hFF00_FF00_FF00_FF00);
        run_case("R1", 64, 4'd3, 2'd1, 64'h0000_0000_0000_F00F, 64'h0000_0000_0000_FF0F);
        run_case("R1", 64, 4'd4, 2'd0, 64'h12, 64'h81);
        run_case("R1", 32, 4'd1, 2'd2, 64'hFFFF_FFFF, 64'h5);
    endtask

    task automatic t_signed_r2_r4();
        run_case("R2", 64, 4'd5, 2'd0, 64'h80, 64'h7F);
        run_case("R2", 64, 4'd6, 2'd0, 64'h80, 64'h7F);
        run_case("R4", 64, 4'd5, 2'd1, 64'hAAAA_0000_0000_8000, 64'h0000_0000_0000_0001);
        run_case("R2", 64, 4'd6, 2'd3, 64'h8000_0000_0000_0000, 64'd5);
        run_case("R2", 32, 4'd5, 2'd2, 64'h8000_0000, 64'h1);
    endtask

    task automatic t_unsigned_r3_r4();
        run_case("R3", 64, 4'd7, 2'd0, 64'h80, 64'h7F);
        run_case("R3", 64, 4'd8, 2'd0, 64'h80, 64'h7F);
        run_case("R4", 64, 4'd8, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0000_8000_0000);
        run_case("R3", 64, 4'd7, 2'd3, 64'h8000_0000_0000_0000, 64'd5);
    endtask

    task automatic t_cas_r5();
        run_case("R5", 64, 4'd9, 2'd2, 64'h1111_2222_8765_4321, 64'h0);
        run_case("R5", 32, 4'd9, 2'd0, 64'hA5, 64'h3C);
    endtask

    task automatic t_return_r6();
        run_case("R6", 64, 4'd7, 2'd1, 64'h1, 64'h0000_0000_0000_9234);
        run_case("R6", 64, 4'd8, 2'd2, 64'h1, 64'h0000_0000_F000_0000);
        run_case("R6", 64, 4'd0, 2'd3, 64'h1, 64'hDEAD_BEEF_0000_0001);
    endtask

    task automatic t_mask_r7();
        for (int w = 0; w < 4; w++)
            run_case("R7", 64, 4'd0, 2'(w), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    endtask

    task automatic t_illegal_r8_r9();
        run_case("R8", 32, 4'd1, 2'd3, 64'h1234, 64'h5678);
        run_case("R9", 64, 4'd10, 2'd2, 64'h1234, 64'h5678);
        run_case("R9", 64, 4'd15, 2'd3, 64'hFFFF, 64'hFFFF);
    endtask

    task automatic t_latency_r10();
        run_case("R10", 64, 4'd0, 2'd0, 64'h11, 64'h22);
        @(negedge clk);
        op = 4'd0; wd = 2'd0; rs2 = 64'h33; ld = 64'h44;
        #1;
        expect_eq("R10", "before edge", st64, 64'h11);
        @(posedge clk);
        @(negedge clk);
        expect_eq("R10", "after edge", st64, 64'h33);
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 10; o++)
            for (int w = 0; w < 4; w++) begin
                run_case("R1", 64, 4'(o), 2'(w), 64'hC3A5_0F81_8E7F_FF80, 64'h7B5A_F07E_7180_007F);
                run_case("R4", 32, 4'(o), 2'(w), 64'h8E7F_FF80, 64'h7180_807F);
            end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_r10();
        rst_n = 1'b1;
        t_basic_r1();
        t_signed_r2_r4();
        t_unsigned_r3_r4();
        t_cas_r5();
        t_return_r6();
        t_mask_r7();
        t_illegal_r8_r9();
        t_latency_r10();
        t_sweep();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule